// File: doc/BRIEF.md
# Front-End Branch Predictor with Static Fallback

This block sits beside the fetch stage and turns a fetch address plus a decoded branch kind into a predicted direction and next fetch address. Dynamic state lives in a direct-mapped target buffer. Each entry holds a valid bit, an address tag, a stored target and a 2-bit saturating history counter. Procedure returns take their target from a 16-entry circular return stack. Calls push their fall-through address onto that stack as they are predicted.

When the target buffer has no entry for the fetch address, a conditional branch uses a fixed rule based on the sign of its displacement. A negative displacement (a loop closing backwards) is predicted taken. A zero or positive displacement is predicted not taken. Far transfers are flagged as not predictable: far calls, interrupt returns and software interrupts.

The target buffer changes only through the retirement port. That port carries the retired address, the actual direction, the actual target and the branch kind. A prediction looks at the buffer but never changes it.

Top module: `bp_front_predictor`

## Requirements
- R1: After synchronous active-low reset, p_valid, p_taken and p_nopred are 0, the target buffer holds no entry, and the return stack is empty.
- R2: For branch kinds far call (5), interrupt return (6) and software interrupt (7), the prediction has p_nopred=1, p_taken=0 and p_next_pc=pc+4. The return stack is left unchanged, and retirement of these kinds leaves the target buffer unchanged.
- R3: Branch kind encodings are none=0, conditional=1, near call=2, near return=3 and near indirect=4. A conditional branch that misses the buffer with a negative displacement (bit 31 of q_disp set) is predicted taken with p_next_pc=pc+disp and p_dyn=0.
- R4: A conditional branch that misses the buffer with a zero or positive displacement is predicted not taken with p_next_pc=pc+4.
- R5: A conditional branch that hits the buffer gives p_dyn=1. It is predicted taken exactly when its counter is 2 or 3, with p_next_pc equal to the stored target when taken and pc+4 when not taken.
- R6: A retired taken branch that misses the buffer allocates an entry with counter 2 and the retired target. A retired not-taken branch that misses allocates nothing.
- R7: On a retired hit, the counter counts up on taken and down on not taken, saturating at 3 and 0. A taken retirement also rewrites the stored target.
- R8: Predictions never change the buffer, so repeated identical queries give identical results.
- R9: A near call pushes pc+4 onto the stack. A near return is predicted taken to the top of the stack and pops it, in last-in first-out order.
- R10: The return stack holds 16 entries and wraps circularly. A push onto a full stack overwrites the oldest entry.
- R11: A return popped from an empty stack yields the entry at the current top position, leaves the stack pointer unchanged and sets p_lowconf=1. Otherwise p_lowconf=0.
- R12: The buffer index is pc[5:2] and the tag is pc[31:6]. An address with a matching index but a different tag is a miss.
- R13: A near call is predicted taken, to the stored target on a hit and to pc+disp on a miss. A near indirect branch is predicted taken to the stored target on a hit and not taken (pc+4) on a miss.
- R14: Every query with q_valid=1 produces a result with p_valid=1 at the next clock edge. A cycle with no query produces p_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| q_valid | input | 1 | Prediction query present |
| q_pc | input | 32 | Fetch address of the branch |
| q_kind | input | 3 | Decoded branch kind |
| q_disp | input | 32 | Two's-complement displacement of a direct branch |
| r_valid | input | 1 | Retirement update present |
| r_pc | input | 32 | Address of the retired branch |
| r_kind | input | 3 | Kind of the retired branch |
| r_taken | input | 1 | Actual direction |
| r_target | input | 32 | Actual target |
| p_valid | output | 1 | Prediction result present |
| p_taken | output | 1 | Predicted direction |
| p_next_pc | output | 32 | Predicted next fetch address |
| p_nopred | output | 1 | Branch kind is never predicted |
| p_dyn | output | 1 | Result came from a buffer hit |
| p_lowconf | output | 1 | Return target came from an empty stack |

## Verification
Every prediction output is registered, so a result is due at the first rising edge after the query is presented. The bench drives each query on a falling edge and reads the result on the next falling edge. A retirement written at one edge first shows up in a query presented in a later cycle, so the bench always lets a retirement finish before it queries the same address. Counter behaviour is checked by sweeping an outcome sequence against an arithmetic saturating count. Return-stack behaviour is checked against a 16-slot circular model of the requirement.

// File: rtl/bp_pkg.sv
// Package: shared branch-kind encoding for the front-end predictor.
// Assumes the decoder supplies one of these eight codes with each query.
package bp_pkg;

    typedef enum logic [2:0] {
        BK_NONE  = 3'd0,
        BK_COND  = 3'd1,
        BK_CALL  = 3'd2,
        BK_RET   = 3'd3,
        BK_IND   = 3'd4,
        BK_FCALL = 3'd5,
        BK_IRET  = 3'd6,
        BK_SWINT = 3'd7
    } br_kind_e;

    // True for transfers the predictor never handles
    function automatic logic kind_is_far(input br_kind_e k);
        return (k == BK_FCALL) || (k == BK_IRET) || (k == BK_SWINT);
    endfunction

    // True for kinds whose retirement trains the target buffer
    function automatic logic kind_trains(input br_kind_e k);
        return (k == BK_COND) || (k == BK_CALL) || (k == BK_IND);
    endfunction

endpackage

// File: rtl/bp_static_dir.sv
// Module: static fallback arithmetic.
// Gives the displacement sign, the displaced target and the fall-through
// address. Assumes fixed-size instructions of INSN_BYTES bytes.
module bp_static_dir #(
    parameter int PC_W       = 32,
    parameter int INSN_BYTES = 4
) (
    input  logic [PC_W-1:0] pc,
    input  logic [PC_W-1:0] disp,
    output logic            backward,
    output logic [PC_W-1:0] disp_target,
    output logic [PC_W-1:0] fall_thru
);

    // Sign bit decides backward versus forward; adders form both addresses
    always_comb begin
        backward    = disp[PC_W-1];
        disp_target = pc + disp;
        fall_thru   = pc + PC_W'(INSN_BYTES);
    end

endmodule

// File: rtl/bp_target_buffer.sv
// Module: direct-mapped branch target buffer with 2-bit history counters.
// Lookup is combinational. Updates come only from the retirement port.
// Assumes ENTRIES is a power of two.
module bp_target_buffer #(
    parameter int PC_W     = 32,
    parameter int ENTRIES  = 16,
    parameter int OFF_BITS = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_hit,
    output logic [PC_W-1:0] lk_target,
    output logic [1:0]      lk_ctr,
    input  logic            upd_en,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken,
    input  logic [PC_W-1:0] upd_target
);

    localparam int IDX_W = $clog2(ENTRIES);
    localparam int TAG_W = PC_W - IDX_W - OFF_BITS;

    logic [ENTRIES-1:0]      vld_q;
    logic [ENTRIES-1:0][1:0] ctr_q;
    logic [TAG_W-1:0]        tag_q [ENTRIES];
    logic [PC_W-1:0]         tgt_q [ENTRIES];

    logic [IDX_W-1:0] lk_idx, u_idx;
    logic [TAG_W-1:0] lk_tag, u_tag;
    logic             u_hit;

    // Split both addresses into index and tag
    always_comb begin
        lk_idx = lk_pc[OFF_BITS +: IDX_W];
        lk_tag = lk_pc[PC_W-1 -: TAG_W];
        u_idx  = upd_pc[OFF_BITS +: IDX_W];
        u_tag  = upd_pc[PC_W-1 -: TAG_W];
    end

    // Prediction-side lookup
    always_comb begin
        lk_hit    = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
        lk_target = tgt_q[lk_idx];
        lk_ctr    = ctr_q[lk_idx];
    end

    // Retirement-side hit detection
    always_comb begin
        u_hit = vld_q[u_idx] && (tag_q[u_idx] == u_tag);
    end

    // Valid bits and counters: train on hit, allocate on taken miss
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            ctr_q <= '0;
        end else if (upd_en) begin
            if (u_hit) begin
                if (upd_taken && ctr_q[u_idx] != 2'd3)
                    ctr_q[u_idx] <= ctr_q[u_idx] + 2'd1;
                else if (!upd_taken && ctr_q[u_idx] != 2'd0)
                    ctr_q[u_idx] <= ctr_q[u_idx] - 2'd1;
            end else if (upd_taken) begin
                vld_q[u_idx] <= 1'b1;
                ctr_q[u_idx] <= 2'd2;
            end
        end
    end

    // Tag and target storage: written on any taken retirement
    always_ff @(posedge clk) begin
        if (upd_en && upd_taken) begin
            tag_q[u_idx] <= u_tag;
            tgt_q[u_idx] <= upd_target;
        end
    end

    AST_CTR_SAT_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && u_hit && upd_taken && ctr_q[u_idx] == 2'd3)
        |=> ctr_q[$past(u_idx)] == 2'd3); // R7
    AST_CTR_SAT_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && u_hit && !upd_taken && ctr_q[u_idx] == 2'd0)
        |=> ctr_q[$past(u_idx)] == 2'd0); // R7
    AST_ALLOC_WEAK: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !u_hit && upd_taken)
        |=> vld_q[$past(u_idx)] && ctr_q[$past(u_idx)] == 2'd2); // R6
    AST_NT_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !u_hit && !upd_taken) |=> $stable(vld_q)); // R6
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_en |=> $stable(vld_q) && $stable(ctr_q)); // R8

endmodule

// File: rtl/bp_return_stack.sv
// Module: circular return address stack.
// A push onto a full stack overwrites the oldest slot. A pop from an empty
// stack keeps the pointer still. Assumes DEPTH is a power of two and that
// push and pop are never requested in the same cycle.
module bp_return_stack #(
    parameter int PC_W  = 32,
    parameter int DEPTH = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic [PC_W-1:0] push_addr,
    input  logic            pop,
    output logic [PC_W-1:0] top_addr,
    output logic            empty
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [PC_W-1:0]  slot_q [DEPTH];
    logic [PTR_W-1:0] tp_q;
    logic [CNT_W-1:0] cnt_q;
    logic [PTR_W-1:0] tp_inc;

    // Next slot for a push (wraps modulo DEPTH)
    always_comb begin
        tp_inc   = tp_q + PTR_W'(1);
        top_addr = slot_q[tp_q];
        empty    = (cnt_q == '0);
    end

    // Pointer and occupancy count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tp_q  <= '0;
            cnt_q <= '0;
        end else if (push) begin
            tp_q <= tp_inc;
            if (cnt_q != CNT_W'(DEPTH))
                cnt_q <= cnt_q + CNT_W'(1);
        end else if (pop && !empty) begin
            tp_q  <= tp_q - PTR_W'(1);
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // Slot storage
    always_ff @(posedge clk) begin
        if (push)
            slot_q[tp_inc] <= push_addr;
    end

    AST_PUSH_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> top_addr == $past(push_addr)); // R9
    AST_FULL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (push && cnt_q == CNT_W'(DEPTH)) |=> cnt_q == CNT_W'(DEPTH)); // R10
    AST_UNDERFLOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && empty) |=> $stable(tp_q) && empty); // R11

endmodule

// File: rtl/bp_front_predictor.sv
// Module: top of the front-end branch predictor.
// Combines the target buffer, the static rule and the return stack into a
// registered prediction one cycle after each query. The buffer is trained
// only from the retirement port. Assumes 4-byte instructions and that a
// query and a retirement for the same address never share a cycle.
module bp_front_predictor
    import bp_pkg::*;
#(
    parameter int PC_W       = 32,
    parameter int BTB_DEPTH  = 16,
    parameter int RAS_DEPTH  = 16,
    parameter int INSN_BYTES = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            q_valid,
    input  logic [PC_W-1:0] q_pc,
    input  logic [2:0]      q_kind,
    input  logic [PC_W-1:0] q_disp,
    input  logic            r_valid,
    input  logic [PC_W-1:0] r_pc,
    input  logic [2:0]      r_kind,
    input  logic            r_taken,
    input  logic [PC_W-1:0] r_target,
    output logic            p_valid,
    output logic            p_taken,
    output logic [PC_W-1:0] p_next_pc,
    output logic            p_nopred,
    output logic            p_dyn,
    output logic            p_lowconf
);

    localparam int OFF_BITS = $clog2(INSN_BYTES);

    br_kind_e        qk, rk;
    logic            btb_hit;
    logic [PC_W-1:0] btb_tgt;
    logic [1:0]      btb_ctr;
    logic            st_back;
    logic [PC_W-1:0] st_tgt, st_fall;
    logic [PC_W-1:0] ras_top;
    logic            ras_empty, ras_push, ras_pop;
    logic            upd_en;

    logic            n_taken, n_nopred, n_dyn, n_low;
    logic [PC_W-1:0] n_tgt;

    // Decode the kind codes
    always_comb begin
        qk = br_kind_e'(q_kind);
        rk = br_kind_e'(r_kind);
    end

    // Retirement gate: only near kinds that carry buffer state train it
    always_comb begin
        upd_en = r_valid && kind_trains(rk);
    end

    bp_target_buffer #(
        .PC_W(PC_W), .ENTRIES(BTB_DEPTH), .OFF_BITS(OFF_BITS)
    ) i_btb (
        .clk(clk), .rst_n(rst_n),
        .lk_pc(q_pc), .lk_hit(btb_hit), .lk_target(btb_tgt), .lk_ctr(btb_ctr),
        .upd_en(upd_en), .upd_pc(r_pc), .upd_taken(r_taken),
        .upd_target(r_target)
    );

    bp_static_dir #(
        .PC_W(PC_W), .INSN_BYTES(INSN_BYTES)
    ) i_static (
        .pc(q_pc), .disp(q_disp),
        .backward(st_back), .disp_target(st_tgt), .fall_thru(st_fall)
    );

    // Stack traffic happens at prediction time
    always_comb begin
        ras_push = q_valid && (qk == BK_CALL);
        ras_pop  = q_valid && (qk == BK_RET);
    end

    bp_return_stack #(
        .PC_W(PC_W), .DEPTH(RAS_DEPTH)
    ) i_ras (
        .clk(clk), .rst_n(rst_n),
        .push(ras_push), .push_addr(st_fall), .pop(ras_pop),
        .top_addr(ras_top), .empty(ras_empty)
    );

    // Choose direction and target per branch kind
    always_comb begin
        n_taken  = 1'b0;
        n_tgt    = st_fall;
        n_nopred = 1'b0;
        n_dyn    = 1'b0;
        n_low    = 1'b0;
        unique case (qk)
            BK_COND: begin
                if (btb_hit) begin
                    n_dyn   = 1'b1;
                    n_taken = btb_ctr[1];
                    n_tgt   = btb_tgt;
                end else begin
                    n_taken = st_back;
                    n_tgt   = st_tgt;
                end
            end
            BK_CALL: begin
                n_taken = 1'b1;
                n_dyn   = btb_hit;
                n_tgt   = btb_hit ? btb_tgt : st_tgt;
            end
            BK_RET: begin
                n_taken = 1'b1;
                n_tgt   = ras_top;
                n_low   = ras_empty;
            end
            BK_IND: begin
                n_dyn   = btb_hit;
                n_taken = btb_hit;
                n_tgt   = btb_tgt;
            end
            BK_FCALL, BK_IRET, BK_SWINT: begin
                n_nopred = 1'b1;
            end
            default: begin
                n_taken = 1'b0;
            end
        endcase
    end

    // Register the prediction for the fetch stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_valid   <= 1'b0;
            p_taken   <= 1'b0;
            p_next_pc <= '0;
            p_nopred  <= 1'b0;
            p_dyn     <= 1'b0;
            p_lowconf <= 1'b0;
        end else begin
            p_valid   <= q_valid;
            p_taken   <= q_valid && n_taken;
            p_next_pc <= n_taken ? n_tgt : st_fall;
            p_nopred  <= q_valid && n_nopred;
            p_dyn     <= q_valid && n_dyn;
            p_lowconf <= q_valid && n_low;
        end
    end

    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        q_valid |=> p_valid); // R14
    AST_LATENCY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !q_valid |=> !p_valid); // R14
    AST_FAR_NOPRED: assert property (@(posedge clk) disable iff (!rst_n)
        (q_valid && kind_is_far(qk)) |=> p_nopred && !p_taken); // R2
    AST_STATIC_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (q_valid && qk == BK_COND && !btb_hit)
        |=> p_taken == $past(q_disp[PC_W-1]) && !p_dyn); // R3
    AST_RET_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (q_valid && qk == BK_RET) |=> p_taken && p_next_pc == $past(ras_top)); // R9

endmodule

// File: tb/test_bp_front_predictor.sv
module test_bp_front_predictor;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        q_valid, r_valid, r_taken;
    logic [31:0] q_pc, q_disp, r_pc, r_target;
    logic [2:0]  q_kind, r_kind;
    logic        p_valid, p_taken, p_nopred, p_dyn, p_lowconf;
    logic [31:0] p_next_pc;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // Return stack model from R9-style rules: 16 circular slots
    logic [31:0] rm [16];
    int rtp = 0;
    int rcnt = 0;

    // Results of the last query
    logic        o_valid, o_taken, o_nopred, o_dyn, o_low;
    logic [31:0] o_next;

    always #10 clk = ~clk;

    bp_front_predictor i_bp_front_predictor (
        .clk(clk), .rst_n(rst_n),
        .q_valid(q_valid), .q_pc(q_pc), .q_kind(q_kind), .q_disp(q_disp),
        .r_valid(r_valid), .r_pc(r_pc), .r_kind(r_kind), .r_taken(r_taken),
        .r_target(r_target),
        .p_valid(p_valid), .p_taken(p_taken), .p_next_pc(p_next_pc),
        .p_nopred(p_nopred), .p_dyn(p_dyn), .p_lowconf(p_lowconf)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Drive one query at a falling edge, sample at the next falling edge
    task automatic query(input logic [31:0] pc, input logic [2:0] k,
                         input logic [31:0] d);
        @(negedge clk);
        q_valid = 1'b1; q_pc = pc; q_kind = k; q_disp = d;
        @(negedge clk);
        q_valid = 1'b0;
        o_valid = p_valid; o_taken = p_taken; o_next = p_next_pc;
        o_nopred = p_nopred; o_dyn = p_dyn; o_low = p_lowconf;
        chk(o_valid == 1'b1, "R14", "p_valid after query", 32'(o_valid), 32'd1);
        if (k == 3'd2) begin
            rtp = (rtp + 1) % 16;
            rm[rtp] = pc + 32'd4;
            if (rcnt < 16) rcnt++;
        end
    endtask

    // Pop the stack model after checking a return
    task automatic model_pop();
        if (rcnt > 0) begin
            rtp = (rtp + 15) % 16;
            rcnt--;
        end
    endtask

    task automatic retire(input logic [31:0] pc, input logic [2:0] k,
                          input logic tk, input logic [31:0] tgt);
        @(negedge clk);
        r_valid = 1'b1; r_pc = pc; r_kind = k; r_taken = tk; r_target = tgt;
        @(negedge clk);
        r_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
        finish_run();
    end

    initial begin
        logic [31:0] a, t, b;
        int c;
        bit pat [12];
        rst_n = 1'b0; q_valid = 0; r_valid = 0;
        q_pc = 0; q_kind = 0; q_disp = 0; r_pc = 0; r_kind = 0;
        r_taken = 0; r_target = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(p_valid == 0 && p_taken == 0 && p_nopred == 0, "R1", "reset outputs",
            {29'd0, p_valid, p_taken, p_nopred}, 32'd0);
        // R14: idle cycle gives no result
        @(negedge clk);
        chk(p_valid == 0, "R14", "idle p_valid", 32'(p_valid), 32'd0);
        // R1 R11: return on empty stack after reset is low confidence
        query(32'h0000_2000, 3'd3, 32'd0);
        chk(o_low == 1 && o_taken == 1, "R11", "empty-stack return lowconf",
            {30'd0, o_low, o_taken}, 32'd3);
        model_pop();

        // R3 R4: static sweep over all 16 indices, both displacement signs
        for (int i = 0; i < 16; i++) begin
            a = 32'h0000_1000 + 32'(i * 4);
            query(a, 3'd1, -32'(i * 8 + 8));
            chk(o_taken == 1 && o_dyn == 0, "R3", "backward miss taken",
                {30'd0, o_taken, o_dyn}, 32'd2);
            chk(o_next == a - 32'(i * 8 + 8), "R3", "backward target", o_next,
                a - 32'(i * 8 + 8));
            query(a, 3'd1, 32'(i * 16));
            chk(o_taken == 0 && o_next == a + 32'd4, "R4", "forward miss",
                o_next, a + 32'd4);
        end

        // R6: not-taken retirement on a miss allocates nothing
        a = 32'h0000_3008; t = 32'h0000_7700;
        retire(a, 3'd1, 1'b0, t);
        query(a, 3'd1, -32'd32);
        chk(o_dyn == 0 && o_next == a - 32'd32, "R6", "no alloc on not-taken",
            o_next, a - 32'd32);
        // R6 R5: taken retirement allocates at counter 2 (predict taken)
        retire(a, 3'd1, 1'b1, t);
        query(a, 3'd1, 32'd16);
        chk(o_dyn == 1 && o_taken == 1 && o_next == t, "R6", "alloc weakly taken",
            o_next, t);

        // R5 R7: counter sweep against an arithmetic saturating count
        pat = '{0, 0, 0, 1, 1, 1, 1, 1, 0, 1, 0, 0};
        c = 2;
        foreach (pat[j]) begin
            retire(a, 3'd1, pat[j], t);
            if (pat[j]) c = (c == 3) ? 3 : c + 1;
            else        c = (c == 0) ? 0 : c - 1;
            query(a, 3'd1, 32'd16);
            chk(o_taken == (c >= 2), "R7", "counter direction", 32'(o_taken),
                32'(c >= 2));
            chk(o_next == ((c >= 2) ? t : a + 32'd4), "R5", "hit next pc",
                o_next, (c >= 2) ? t : a + 32'd4);
        end
        // R7: taken retirement rewrites target
        retire(a, 3'd1, 1'b1, 32'h0000_9900);
        query(a, 3'd1, 32'd16);
        chk(o_next == 32'h0000_9900, "R7", "target rewrite", o_next, 32'h0000_9900);

        // R8: repeated queries leave the buffer untouched
        for (int k = 0; k < 4; k++) begin
            query(a, 3'd1, -32'd8);
            chk(o_dyn == 1 && o_next == 32'h0000_9900, "R8", "query repeat",
                o_next, 32'h0000_9900);
        end

        // R12: same index, different tag misses
        query(a + 32'd64, 3'd1, 32'd40);
        chk(o_dyn == 0 && o_taken == 0 && o_next == a + 32'd68, "R12",
            "alias miss", o_next, a + 32'd68);

        // R2: far kinds are not predicted and leave stack and buffer alone
        b = 32'h0000_4010;
        query(32'h0000_5000, 3'd2, 32'h0000_0100);  // push 0x5004
        for (int k = 5; k < 8; k++) begin
            query(b, 3'(k), -32'd16);
            chk(o_nopred == 1 && o_taken == 0 && o_next == b + 32'd4, "R2",
                "far no prediction", {o_nopred, o_taken, o_next[29:0]},
                {2'b10, 30'(b + 32'd4)});
            retire(b, 3'(k), 1'b1, 32'h0000_AA00);
        end
        query(b, 3'd1, 32'd8);
        chk(o_dyn == 0, "R2", "far retire no alloc", 32'(o_dyn), 32'd0);
        query(32'h0000_6000, 3'd3, 32'd0);
        chk(o_next == 32'h0000_5004 && o_low == 0, "R2", "stack kept across far",
            o_next, 32'h0000_5004);
        model_pop();

        // R13: indirect and call behaviour on miss and hit
        b = 32'h0000_4020;
        query(b, 3'd4, 32'd0);
        chk(o_taken == 0 && o_next == b + 32'd4, "R13", "indirect miss",
            o_next, b + 32'd4);
        retire(b, 3'd4, 1'b1, 32'h0000_BB00);
        query(b, 3'd4, 32'd0);
        chk(o_taken == 1 && o_dyn == 1 && o_next == 32'h0000_BB00, "R13",
            "indirect hit", o_next, 32'h0000_BB00);
        b = 32'h0000_4030;
        query(b, 3'd2, 32'h0000_0200);
        chk(o_taken == 1 && o_next == b + 32'h200, "R13", "call miss",
            o_next, b + 32'h200);
        retire(b, 3'd2, 1'b1, 32'h0000_CC00);
        query(b, 3'd2, 32'h0000_0200);
        chk(o_dyn == 1 && o_next == 32'h0000_CC00, "R13", "call hit",
            o_next, 32'h0000_CC00);

        // R9: LIFO order of returns
        for (int k = 0; k < 3; k++)
            query(32'h0001_0000 + 32'(k * 32), 3'd2, 32'd64);
        for (int k = 2; k >= 0; k--) begin
            query(32'h0002_0000, 3'd3, 32'd0);
            chk(o_next == 32'h0001_0004 + 32'(k * 32) && o_low == 0, "R9",
                "return order", o_next, 32'h0001_0004 + 32'(k * 32));
            model_pop();
        end

        // R10 R11: overflow with 17 calls then drain past empty
        for (int k = 0; k < 17; k++)
            query(32'h0003_0000 + 32'(k * 16), 3'd2, 32'd64);
        for (int k = 0; k < 20; k++) begin
            query(32'h0002_0000, 3'd3, 32'd0);
            if (k < 16)
                chk(o_next == 32'h0003_0004 + 32'((16 - k) * 16) && o_low == 0,
                    "R10", "wrapped return", o_next,
                    32'h0003_0004 + 32'((16 - k) * 16));
            else
                chk(o_low == 1 && o_next == rm[rtp], "R11", "underflow return",
                    o_next, rm[rtp]);
            model_pop();
        end
        finish_run();
    end

endmodule